// File: doc/BRIEF.md
# Start-Condition Kicked Watchdog Timer

This block watches a two-wire serial bus and uses it as a liveness signal for the host. Each start condition restarts the timeout count. A start condition is the data line falling while the clock line is high. If the host issues no start condition within the selected period, the block raises a bite request to the chip's reset generator. The block then waits for that generator to assert and release its reset before it counts again.

The period comes from a 2-bit select field held in a small configuration register, which is loaded through a write port. Three codes pick one of three periods. The periods are parameters in clock ticks, so a simulation can use short values. The fourth code turns the watchdog off. A guard bit in the same register can freeze the register: while the external write-protect input is high and the guard bit is set, writes have no effect.

Top module: `bus_start_watchdog`

## Requirements
- R1: A start condition on the synchronized lines clears the timeout count, so start conditions spaced closer than the period keep `wd_bite` low for any length of time.
- R2: If no start condition occurs, `wd_bite` rises a number of cycles equal to the selected period (plus three cycles of synchronizer and detection latency) after the last restart.
- R3: `period_sel` code 0 selects `LIM0` ticks, code 1 selects `LIM1` ticks and code 2 selects `LIM2` ticks.
- R4: While `period_sel` is 3 or `wd_enable` is low, the count is held at zero and `wd_bite` never rises; after re-enabling, a full period elapses before a bite.
- R5: A write (`cfg_we` high) that is not blocked loads `cfg_period` into `period_sel` and `cfg_guard` into `guard_en` on the next edge.
- R6: While `wp_pin` is high and `guard_en` is 1, a write leaves both `period_sel` and `guard_en` unchanged.
- R7: A data line held constantly high or constantly low times out. A data fall while the clock line is low does not restart the count.
- R8: `wd_bite` stays high until `sys_rst_hold` is seen high and then drops. The count stays idle while `sys_rst_hold` is high and restarts from zero once it goes low.
- R9: After `rst_n` is released, `period_sel` is 0, `guard_en` is 0 and `wd_bite` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| wd_enable | input | 1 | Watchdog enable |
| wp_pin | input | 1 | External write-protect |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_period | input | 2 | Period select to write (3 = off) |
| cfg_guard | input | 1 | Guard bit to write |
| sys_rst_hold | input | 1 | Reset generator output, high while system reset is active |
| period_sel | output | 2 | Current period select |
| guard_en | output | 1 | Current guard bit |
| wd_bite | output | 1 | Timeout request to the reset generator |

## Verification
The assertions check the configuration register on every cycle: blocked writes, accepted writes, and the rule that a bite can only rise while the watchdog is armed. They also check the bite handshake with the reset generator (it holds until the generator responds, then drops). Only the bench scenarios can show the timing behaviour. This covers the exact period for each select code, restarts by start conditions, stuck-high and stuck-low lines, data falls that occur with the clock low, and the full period that follows a reset release or a re-enable.

// File: rtl/bus_start_watchdog.sv
module bus_start_watchdog #(
  parameter int unsigned LIM0 = 25000,
  parameter int unsigned LIM1 = 100000,
  parameter int unsigned LIM2 = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       wd_enable,
  input  logic       wp_pin,
  input  logic       cfg_we,
  input  logic [1:0] cfg_period,
  input  logic       cfg_guard,
  input  logic       sys_rst_hold,
  output logic [1:0] period_sel,
  output logic       guard_en,
  output logic       wd_bite
);
  localparam int unsigned MAXL = (LIM0 > LIM1) ? ((LIM0 > LIM2) ? LIM0 : LIM2)
                                               : ((LIM1 > LIM2) ? LIM1 : LIM2);
  localparam int CW = $clog2(MAXL + 1);

  typedef enum logic [1:0] {S_RUN, S_BITE, S_HOLD} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_d, sda_d;
  logic          start_seen, armed;
  logic [CW-1:0] cnt, lim;
  st_t           st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end
  end

  assign start_seen = scl_sy[1] & scl_d & sda_d & ~sda_sy[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_sel <= 2'b00;
      guard_en   <= 1'b0;
    end else if (cfg_we && !(wp_pin && guard_en)) begin
      period_sel <= cfg_period;
      guard_en   <= cfg_guard;
    end
  end

  always_comb begin
    case (period_sel)
      2'b00:   lim = CW'(LIM0);
      2'b01:   lim = CW'(LIM1);
      default: lim = CW'(LIM2);
    endcase
  end

  assign armed = wd_enable && (period_sel != 2'b11) && !sys_rst_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      case (st)
        S_RUN: begin
          if (!armed || start_seen) begin
            cnt <= '0;
          end else if (cnt >= lim - CW'(1)) begin
            cnt <= '0;
            st  <= S_BITE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_BITE: begin
          cnt <= '0;
          if (sys_rst_hold) st <= S_HOLD;
        end
        default: begin
          cnt <= '0;
          if (!sys_rst_hold) st <= S_RUN;
        end
      endcase
    end
  end

  assign wd_bite = (st == S_BITE);
endmodule

// File: rtl/bus_start_watchdog_sva.sv
module bus_start_watchdog_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       wd_enable,
  input logic       wp_pin,
  input logic       cfg_we,
  input logic [1:0] cfg_period,
  input logic       cfg_guard,
  input logic       sys_rst_hold,
  input logic [1:0] period_sel,
  input logic       guard_en,
  input logic       wd_bite
);
  p_locked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wp_pin && guard_en) |=> ($stable(period_sel) && $stable(guard_en)));

  p_open_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !(wp_pin && guard_en)) |=>
      (period_sel == $past(cfg_period) && guard_en == $past(cfg_guard)));

  p_bite_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_bite) |-> ($past(wd_enable) && $past(period_sel) != 2'b11));

  p_bite_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_bite && !sys_rst_hold) |=> wd_bite);

  p_bite_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_bite && sys_rst_hold) |=> !wd_bite);
endmodule

bind bus_start_watchdog bus_start_watchdog_sva u_sva (
  .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .wp_pin(wp_pin),
  .cfg_we(cfg_we), .cfg_period(cfg_period), .cfg_guard(cfg_guard),
  .sys_rst_hold(sys_rst_hold), .period_sel(period_sel),
  .guard_en(guard_en), .wd_bite(wd_bite)
);

// File: tb/bus_start_watchdog_bench.sv
module bus_start_watchdog_bench;
  localparam int L0 = 16;
  localparam int L1 = 28;
  localparam int L2 = 44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic wd_enable = 1'b1, wp_pin = 1'b0, cfg_we = 1'b0, cfg_guard = 1'b0;
  logic [1:0] cfg_period = 2'b00;
  logic sys_rst_hold = 1'b0;
  logic [1:0] period_sel;
  logic guard_en, wd_bite;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bus_start_watchdog #(.LIM0(L0), .LIM1(L1), .LIM2(L2)) u_bus_start_watchdog (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .wd_enable(wd_enable), .wp_pin(wp_pin), .cfg_we(cfg_we),
    .cfg_period(cfg_period), .cfg_guard(cfg_guard), .sys_rst_hold(sys_rst_hold),
    .period_sel(period_sel), .guard_en(guard_en), .wd_bite(wd_bite)
  );

  // {sel[1:0], kicks[2:0]}
  localparam logic [4:0] VEC [6] = '{5'b00_001, 5'b01_011, 5'b10_010,
                                     5'b00_100, 5'b01_001, 5'b10_001};

  function automatic int lim_of(input logic [1:0] s);
    return (s == 2'd0) ? L0 : (s == 2'd1) ? L1 : L2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic g);
    @(negedge clk);
    cfg_we = 1'b1; cfg_period = s; cfg_guard = g;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic recover();
    @(negedge clk); sys_rst_hold = 1'b1;
    wait_n(2);
    sys_rst_hold = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); sda_in = 1'b0;
    wait_n(3);
    sda_in = 1'b1;
    wait_n(2);
  endtask

  initial begin
    wait_n(150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);
    chk("R9 sel", period_sel, 0);
    chk("R9 guard", guard_en, 0);
    chk("R9 bite", wd_bite, 0);

    for (int v = 0; v < 6; v++) begin
      int l;
      l = lim_of(VEC[v][4:3]);
      wr(VEC[v][4:3], 1'b0);
      recover();
      for (int k = 0; k < int'(VEC[v][2:0]); k++) begin
        kick();
        if (k != int'(VEC[v][2:0]) - 1) wait_n(l - 8);
      end
      wait_n(l - 5);
      chk("R1 R3 no bite before period", wd_bite, 0);
      wait_n(4);
      chk("R2 R3 bite at period", wd_bite, 1);
      recover();
    end

    wr(2'b00, 1'b0);
    recover();
    wait_n(L0 + 6);
    chk("R7 stuck high times out", wd_bite, 1);
    recover();
    @(negedge clk); sda_in = 1'b0;
    wait_n(L0 + 8);
    chk("R7 stuck low times out", wd_bite, 1);
    sda_in = 1'b1;
    recover();

    wait_n(L0 - 7);
    scl_in = 1'b0; wait_n(1);
    sda_in = 1'b0; wait_n(2);
    sda_in = 1'b1; wait_n(1);
    scl_in = 1'b1;
    wait_n(5);
    chk("R7 data fall with clock low ignored", wd_bite, 1);
    recover();

    wr(2'b11, 1'b0);
    recover();
    wait_n(L2 + 10);
    chk("R4 code 3 disables", wd_bite, 0);
    wr(2'b00, 1'b0);
    @(negedge clk); wd_enable = 1'b0;
    wait_n(L0 + 10);
    chk("R4 enable low disables", wd_bite, 0);
    wd_enable = 1'b1;
    wait_n(L0 - 3);
    chk("R4 full period after enable", wd_bite, 0);
    wait_n(5);
    chk("R4 bite after enable period", wd_bite, 1);

    wait_n(10);
    chk("R8 bite holds without ack", wd_bite, 1);
    @(negedge clk); sys_rst_hold = 1'b1;
    wait_n(1);
    chk("R8 bite drops on ack", wd_bite, 0);
    wait_n(L0 + 10);
    chk("R8 idle while hold", wd_bite, 0);
    sys_rst_hold = 1'b0;
    wait_n(L0 - 3);
    chk("R8 full period after release", wd_bite, 0);
    wait_n(6);
    chk("R8 bite after release period", wd_bite, 1);
    recover();

    wr(2'b01, 1'b1);
    chk("R5 sel written", period_sel, 1);
    chk("R5 guard written", guard_en, 1);
    @(negedge clk); wp_pin = 1'b1;
    wr(2'b10, 1'b0);
    chk("R6 sel frozen", period_sel, 1);
    chk("R6 guard frozen", guard_en, 1);
    @(negedge clk); wp_pin = 1'b0;
    wr(2'b10, 1'b0);
    chk("R5 sel after unlock", period_sel, 2);
    chk("R5 guard after unlock", guard_en, 0);
    @(negedge clk); wp_pin = 1'b1;
    wr(2'b00, 1'b0);
    chk("R5 wp alone does not block", period_sel, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule